// File: doc/BRIEF.md
# RAM Access-Protection Violation Monitor

This block sits beside a group of RAM blocks and watches three request streams aimed at them: CPU data writes, DMA writes and CPU instruction fetches. Each RAM block occupies a fixed, equally sized address window and carries three protection attributes of its own: CPU write-protect, DMA write-protect and fetch-protect. When a request lands in a block whose matching attribute is set, a sticky violation flag for that kind of access is raised. A protected DMA write has its write strobe to the RAM removed in the same cycle, so the RAM is never modified.

Software reaches the block through a simple word-addressed register bus: a read-only flag register, a write-1-to-set force register, a write-1-to-clear clear register, and one protection register per RAM block. Flag, force, clear and protection registers share one bit layout. An error output is high whenever any flag is set and is meant to be routed to an interrupt controller.

Top module: `ramprot_monitor`

## Requirements
- R1: After reset all flags, all protection registers and `err_out` are 0.
- R2: A CPU write whose address falls in a block with CPU write-protect set raises flag bit 2 on the next clock edge.
- R3: A DMA write to a block with DMA write-protect set raises flag bit 1 on the next edge, and `ram_dma_we` is held low in the same cycle; a DMA write to a block without that attribute passes `dma_wr_vld` through to `ram_dma_we`.
- R4: A CPU fetch from a block with fetch-protect set raises flag bit 0 on the next edge.
- R5: A set flag stays set on every following cycle until it is cleared through the clear register.
- R6: Writing the clear register (offset 2) with a 1 in a bit position clears that flag on the next edge; 0 bits have no effect, and the register reads as 0.
- R7: Writing the force register (offset 1) with a 1 in a bit position sets that flag on the next edge; 0 bits have no effect, and the register reads as 0.
- R8: When a hardware violation or a force and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: Block k covers addresses BASE + k*2^BLK_AW up to BASE + (k+1)*2^BLK_AW - 1; a request outside all blocks never raises a flag, even with every attribute set.
- R10: `err_out` is 1 exactly when at least one flag is set.
- R11: The protection register of block k sits at offset 4+k, bit 0 fetch-protect, bit 1 DMA write-protect, bit 2 CPU write-protect; it reads back what was written, and bits 31..3 of every register read as 0 (the flag register at offset 0 included).
- R12: A request to a block whose attribute for that access kind is clear raises no flag, even if the block's other attributes are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_vld | input | 1 | CPU data write request this cycle |
| cpu_wr_addr | input | ADDR_W | CPU write address |
| dma_wr_vld | input | 1 | DMA write request this cycle |
| dma_wr_addr | input | ADDR_W | DMA write address |
| cpu_fetch_vld | input | 1 | CPU instruction fetch this cycle |
| cpu_fetch_addr | input | ADDR_W | CPU fetch address |
| ram_dma_we | output | 1 | DMA write strobe to the RAM, removed on a protected write |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| err_out | output | 1 | High while any violation flag is set |

## Verification
The two functions that collide are a hardware flag set and a software clear of the same flag in one cycle. The bench provokes this by first leaving the CPU-write flag set, then issuing in a single cycle a fetch into a fetch-protected block together with a clear register write covering both the fetch and CPU-write bits. The outcome is judged through the flag register on the next cycle: the fetch flag must survive its own clear while the CPU-write flag must be gone, which separates set priority from an ordinary clear.

// File: rtl/ramprot_pkg.sv
// Package: shared types and register offsets of the RAM protection monitor.
// Assumes: the three violation kinds keep the same bit position in the flag,
// force, clear and per-block protection registers.
package ramprot_pkg;

    // One bit per violation kind; packed MSB first so cpu_wr is bit 2.
    typedef struct packed {
        logic cpu_wr;   // bit 2: CPU data write
        logic dma_wr;   // bit 1: DMA write
        logic fetch;    // bit 0: CPU instruction fetch
    } vio_t;

    localparam int unsigned VIO_W     = $bits(vio_t);
    localparam int unsigned OFS_FLAG  = 0;
    localparam int unsigned OFS_FORCE = 1;
    localparam int unsigned OFS_CLEAR = 2;
    localparam int unsigned OFS_PROT  = 4;

endpackage

// File: rtl/ramprot_decode.sv
// Module: address-to-block decoder.
// Maps one request address onto a one-hot vector of RAM block hits. Blocks
// are NUM_BLK contiguous windows of 2**BLK_AW words starting at BASE.
// Assumes: BASE + NUM_BLK*2**BLK_AW fits in ADDR_W+1 bits; purely combinational.
module ramprot_decode #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_BLK = 4,
    parameter int unsigned BLK_AW  = 10,
    parameter int unsigned BASE    = 32'h8000
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_BLK-1:0] hit
);

    localparam int unsigned IDX_W = ADDR_W - BLK_AW;
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(NUM_BLK) << BLK_AW;

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] off;
    logic            in_range;

    // Offset from the window base and overall range check.
    always_comb begin
        addr_x   = {1'b0, addr};
        off      = addr_x - BASE_X;
        in_range = (addr_x >= BASE_X) && (off < SPAN_X);
    end

    // One comparator per block on the upper offset bits.
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_hit
        assign hit[k] = in_range && (off[ADDR_W-1:BLK_AW] == IDX_W'(k));
    end

endmodule

// File: rtl/ramprot_attr_regs.sv
// Module: per-block protection attribute registers.
// Holds one vio_t of protect bits for each RAM block, written whole from the
// register bus. Assumes: wr_idx < NUM_BLK whenever wr_en is high.
module ramprot_attr_regs
    import ramprot_pkg::*;
#(
    parameter int unsigned NUM_BLK = 4,
    localparam int unsigned IW     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  vio_t                 wr_data,
    output vio_t [NUM_BLK-1:0]   prot
);

    vio_t [NUM_BLK-1:0] prot_q;

    // One register per block; loaded only when its index is written.
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n)
                prot_q[k] <= '0;
            else if (wr_en && (wr_idx == IW'(k)))
                prot_q[k] <= wr_data;
        end
    end

    assign prot = prot_q;

    AST_PROT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (prot_q[$past(wr_idx)] == $past(wr_data))); // R11

endmodule

// File: rtl/ramprot_flags.sv
// Module: sticky violation flags.
// Each flag is set by a hardware violation or a force, cleared by a clear
// strobe, and set beats clear when both arrive in one cycle.
// Assumes: set and clear inputs are single-cycle strobes from the top.
module ramprot_flags
    import ramprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vio_t hw_set,
    input  vio_t frc_set,
    input  vio_t clr,
    output vio_t flags
);

    vio_t flags_q;
    vio_t set_all;

    // Merge the two set sources.
    assign set_all = hw_set | frc_set;

    // Sticky flag update with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr) | set_all;
    end

    assign flags = flags_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr))); // R5
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((flags_q & $past(set_all)) == $past(set_all))); // R8
    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set_all) != '0) |=> ((flags_q & $past(clr & ~set_all)) == '0)); // R6

endmodule

// File: rtl/ramprot_monitor.sv
// Module: RAM access-protection violation monitor (top).
// Decodes the CPU write, DMA write and CPU fetch addresses to RAM blocks,
// compares them with the per-block protect bits, raises sticky flags, gates
// protected DMA writes and serves the register bus.
// Assumes: REG_AW wide enough for offset OFS_PROT + NUM_BLK - 1; reads are
// combinational and side-effect free.
module ramprot_monitor
    import ramprot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_BLK = 4,
    parameter int unsigned BLK_AW  = 10,
    parameter int unsigned BASE    = 32'h8000,
    parameter int unsigned REG_AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_vld,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic              dma_wr_vld,
    input  logic [ADDR_W-1:0] dma_wr_addr,
    input  logic              cpu_fetch_vld,
    input  logic [ADDR_W-1:0] cpu_fetch_addr,
    output logic              ram_dma_we,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_out
);

    localparam int unsigned IW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam logic [REG_AW-1:0] A_FLAG  = REG_AW'(OFS_FLAG);
    localparam logic [REG_AW-1:0] A_FORCE = REG_AW'(OFS_FORCE);
    localparam logic [REG_AW-1:0] A_CLEAR = REG_AW'(OFS_CLEAR);
    localparam logic [REG_AW-1:0] A_PROT  = REG_AW'(OFS_PROT);
    localparam logic [REG_AW-1:0] N_BLK   = REG_AW'(NUM_BLK);

    logic [NUM_BLK-1:0] cpu_hit, dma_hit, fch_hit;
    logic [NUM_BLK-1:0] cpu_wp, dma_wp, fch_p;
    vio_t [NUM_BLK-1:0] prot;
    vio_t               hw_set, frc_set, clr, flags, wr_bits;
    logic [REG_AW-1:0]  blk_off;
    logic               is_blk, prot_we;
    logic               unused_wdata_hi;

    // Address decoders, one per request stream.
    ramprot_decode #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW), .BASE(BASE))
        u_dec_cpu (.addr(cpu_wr_addr), .hit(cpu_hit));
    ramprot_decode #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW), .BASE(BASE))
        u_dec_dma (.addr(dma_wr_addr), .hit(dma_hit));
    ramprot_decode #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW), .BASE(BASE))
        u_dec_fch (.addr(cpu_fetch_addr), .hit(fch_hit));

    // Split the per-block attribute structs into per-kind vectors.
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_attr
        assign cpu_wp[k] = prot[k].cpu_wr;
        assign dma_wp[k] = prot[k].dma_wr;
        assign fch_p[k]  = prot[k].fetch;
    end

    // Violation detection per access kind.
    always_comb begin
        hw_set.cpu_wr = cpu_wr_vld    && |(cpu_hit & cpu_wp);
        hw_set.dma_wr = dma_wr_vld    && |(dma_hit & dma_wp);
        hw_set.fetch  = cpu_fetch_vld && |(fch_hit & fch_p);
    end

    // Suppress the RAM write strobe of a protected DMA write.
    assign ram_dma_we = dma_wr_vld && !hw_set.dma_wr;

    // Register bus write decode.
    always_comb begin
        wr_bits = vio_t'(reg_wdata[VIO_W-1:0]);
        blk_off = reg_addr - A_PROT;
        is_blk  = (reg_addr >= A_PROT) && (blk_off < N_BLK);
        frc_set = (reg_wr_en && reg_addr == A_FORCE) ? wr_bits : '0;
        clr     = (reg_wr_en && reg_addr == A_CLEAR) ? wr_bits : '0;
        prot_we = reg_wr_en && is_blk;
    end

    assign unused_wdata_hi = ^reg_wdata[31:VIO_W];

    ramprot_attr_regs #(.NUM_BLK(NUM_BLK)) u_attr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prot_we),
        .wr_idx  (blk_off[IW-1:0]),
        .wr_data (wr_bits),
        .prot    (prot)
    );

    ramprot_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .frc_set (frc_set),
        .clr     (clr),
        .flags   (flags)
    );

    // Register read mux; force and clear read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_FLAG)
            reg_rdata[VIO_W-1:0] = flags;
        else if (is_blk)
            reg_rdata[VIO_W-1:0] = prot[blk_off[IW-1:0]];
    end

    // Error line follows the flag register.
    assign err_out = |flags;

    AST_DMA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_vld && |(dma_hit & dma_wp)) |-> !ram_dma_we); // R3
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_hit) && $onehot0(dma_hit) && $onehot0(fch_hit)); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_out) |-> $past((hw_set | frc_set) != '0)); // R10
    AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_out) |-> $past(clr != '0)); // R6

endmodule

// File: tb/tb_ramprot_monitor.sv
// Scoreboard bench: the driver pushes the expected flag register value after
// each cycle of stimulus, a monitor pops and compares at the falling edge.
module tb_ramprot_monitor;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_vld = 1'b0, dma_wr_vld = 1'b0, cpu_fetch_vld = 1'b0;
    logic [15:0] cpu_wr_addr = '0, dma_wr_addr = '0, cpu_fetch_addr = '0;
    logic        ram_dma_we;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] flags;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_NS/2) clk = ~clk;

    ramprot_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_vld(cpu_wr_vld), .cpu_wr_addr(cpu_wr_addr),
        .dma_wr_vld(dma_wr_vld), .dma_wr_addr(dma_wr_addr),
        .cpu_fetch_vld(cpu_fetch_vld), .cpu_fetch_addr(cpu_fetch_addr),
        .ram_dma_we(ram_dma_we),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_out(err_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare the flag register and error line with the scoreboard.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(reg_rdata === e.flags, {e.tag, " flags"}, reg_rdata, e.flags);
            chk(err_out === (e.flags != 0), "R10 err_out", 32'(err_out), 32'(e.flags != 0));
        end
    end

    // Driver: apply one cycle of stimulus, then push the expected flags.
    task automatic step(input bit cw, input logic [15:0] cwa,
                        input bit dw, input logic [15:0] dwa,
                        input bit fv, input logic [15:0] fa,
                        input bit rw, input logic [3:0] ra, input logic [31:0] wd,
                        input logic [31:0] exp_flags, input string tag);
        cpu_wr_vld = cw; cpu_wr_addr = cwa;
        dma_wr_vld = dw; dma_wr_addr = dwa;
        cpu_fetch_vld = fv; cpu_fetch_addr = fa;
        reg_wr_en = rw; reg_addr = ra; reg_wdata = wd;
        @(posedge clk); #1;
        cpu_wr_vld = 0; dma_wr_vld = 0; cpu_fetch_vld = 0;
        reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
        sb_q.push_back('{exp_flags, tag});
        @(negedge clk); #1;
    endtask

    task automatic idle(input logic [31:0] exp_flags, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, exp_flags, tag);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d,
                        input logic [31:0] exp_flags, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, a, d, exp_flags, tag);
    endtask

    task automatic rreg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
        reg_addr = 0; #1;
    endtask

    // Watchdog.
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;

        // R1: reset state
        rreg(0, 0, "R1 flag reg after reset");
        chk(err_out === 1'b0, "R1 err_out after reset", 32'(err_out), 0);
        for (int k = 0; k < 4; k++) rreg(4'(4 + k), 0, "R1 prot reg after reset");

        // R11: protection registers; blk0 cpu-wp, blk1 dma-wp, blk2 fetch-p, blk3 all
        wreg(4, 32'hFFFF_FFFC, 0, "R11 prot write blk0");
        wreg(5, 32'h0000_0002, 0, "R11 prot write blk1");
        wreg(6, 32'h0000_0001, 0, "R11 prot write blk2");
        wreg(7, 32'h0000_0007, 0, "R11 prot write blk3");
        rreg(4, 32'h4, "R11 readback blk0 upper bits zero");
        rreg(5, 32'h2, "R11 readback blk1");
        rreg(6, 32'h1, "R11 readback blk2");
        rreg(7, 32'h7, "R11 readback blk3");

        // R12: CPU write to block without CPU write-protect
        step(1, 16'h8400, 0, 0, 0, 0, 0, 0, 0, 0, "R12 cpu write unprotected blk1");
        // R2: CPU write to protected block
        step(1, 16'h8010, 0, 0, 0, 0, 0, 0, 0, 32'h4, "R2 cpu write protected blk0");
        // R5: sticky
        idle(32'h4, "R5 flag holds");
        idle(32'h4, "R5 flag holds again");
        // R6: clear with zero has no effect, then clear bit 2
        wreg(2, 32'h0, 32'h4, "R6 clear zero no effect");
        wreg(2, 32'h4, 32'h0, "R6 clear bit2");

        // R3: protected DMA write gated
        dma_wr_vld = 1; dma_wr_addr = 16'h8500; #1;
        chk(ram_dma_we === 1'b0, "R3 protected dma strobe gated", 32'(ram_dma_we), 0);
        step(0, 0, 1, 16'h8500, 0, 0, 0, 0, 0, 32'h2, "R3 dma write protected blk1");
        dma_wr_vld = 1; dma_wr_addr = 16'h8000; #1;
        chk(ram_dma_we === 1'b1, "R3 unprotected dma strobe passes", 32'(ram_dma_we), 1);
        step(0, 0, 1, 16'h8000, 0, 0, 0, 0, 0, 32'h2, "R12 dma write blk0 no flag");

        // R4: fetch protected
        step(0, 0, 0, 0, 1, 16'h8800, 0, 0, 0, 32'h3, "R4 fetch protected blk2");
        // R9: out of range never flags, boundary inside does
        step(1, 16'h7FFF, 1, 16'h7FFF, 1, 16'h7FFF, 0, 0, 0, 32'h3, "R9 below window");
        step(1, 16'h9000, 1, 16'h9000, 1, 16'h9000, 0, 0, 0, 32'h3, "R9 above window");
        step(1, 16'h8FFF, 0, 0, 0, 0, 0, 0, 0, 32'h7, "R9 last word of blk3");
        wreg(2, 32'h7, 32'h0, "R6 clear all");

        // R7: force
        wreg(1, 32'h0, 32'h0, "R7 force zero no effect");
        wreg(1, 32'h5, 32'h5, "R7 force bits 0 and 2");
        rreg(1, 0, "R7 force reads zero");
        rreg(2, 0, "R6 clear reads zero");
        wreg(2, 32'h7, 32'h0, "R6 clear after force");

        // R8: set wins over clear in same cycle
        step(1, 16'h8004, 0, 0, 0, 0, 0, 0, 0, 32'h4, "R8 setup cpu flag");
        step(0, 0, 0, 0, 1, 16'h8C00, 1, 2, 32'h5, 32'h1, "R8 fetch set beats clear");
        wreg(1, 32'h2, 32'h3, "R8 force dma");
        wreg(2, 32'h3, 32'h0, "R6 final clear");
        idle(0, "R5 cleared stays clear");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule